// File: doc/BRIEF.md
# Test-Sequence Data Inserter for Framed Streams

This block sits in a framed streaming path and, when enabled, replaces the data word of every valid beat with a locally generated test value. The start, end, sync, channel and valid markers travel through untouched, so the framing seen downstream is exactly the framing that arrived. Every beat, valid or not, passes one output register.

Two generators are available: a binary up-counter and a Galois linear-feedback shift register. A mode input picks one of them. Only the selected generator steps, and it steps once for each valid beat. Each valid beat therefore acts as the request for the next test word, and the sequence never runs ahead of or behind the traffic. When the enable is low the input data passes through unchanged and both generators hold their state.

A build-time option removes the input stream. The block then becomes a self-timed source that emits one valid test word on every enabled cycle.

Top module: `tseq_inserter`

## Requirements
- R1: With HAS_INPUT=1, out_valid, out_sop, out_eop, out_sync and out_chan equal in_valid, in_sop, in_eop, in_sync and in_chan one clock cycle earlier, whatever the state of en and mode.
- R2: While en is 0, out_data equals in_data of the previous cycle.
- R3: With mode=0 (counter), the enabled output data is the counter value. The counter is 0 after reset, rises by one after each enabled valid beat, and wraps from 2^SEQ_W-1 to 0.
- R4: Enabled beats with in_valid=0 do not advance either generator. Such a beat carries the current value unchanged.
- R5: With mode=1 (pseudo-random), the enabled output data is the register state s, and after each enabled valid beat s becomes (s>>1) XOR MASK if s[0]=1, otherwise s>>1. MASK is 0xC for SEQ_W=4, 0xB8 for 8, 0xB400 for 16, 0xE10000 for 24 and 0x80200003 for 32.
- R6: The pseudo-random register holds seed 1 after reset. It is reloaded to 1 on the first cycle of every enabled period (en high after a low cycle), and that cycle carries the seed.
- R7: While en is 0 neither generator changes. After re-enable the counter resumes from the value it held.
- R8: While enabled, out_data bits DATA_W-1 down to SEQ_W are zero.
- R9: With HAS_INPUT=0, out_valid is 1 one cycle after each enabled cycle and 0 otherwise. sop, eop, sync and channel are 0, and the data follows R3/R5 with every enabled cycle counting as a valid beat.
- R10: While rst is high, and on the first cycle after it, all outputs are 0.
- R11: The pseudo-random sequence never produces 0 and repeats after exactly 2^SEQ_W-1 valid beats.
- R12: Only the generator selected by mode advances. After a mode switch, each generator resumes from its own held state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enables data replacement (and generation in source mode) |
| mode | input | 1 | 0 = counter, 1 = pseudo-random |
| in_valid | input | 1 | Input beat valid |
| in_sop | input | 1 | Input start of frame |
| in_eop | input | 1 | Input end of frame |
| in_sync | input | 1 | Input sync marker |
| in_chan | input | CH_W | Input channel tag |
| in_data | input | DATA_W | Input data word |
| out_valid | output | 1 | Output beat valid |
| out_sop | output | 1 | Output start of frame |
| out_eop | output | 1 | Output end of frame |
| out_sync | output | 1 | Output sync marker |
| out_chan | output | CH_W | Output channel tag |
| out_data | output | DATA_W | Output data word |

## Verification
The assertions check four things on every cycle: framing alignment across the register, pass-through of data while disabled, the zero upper bits, and that the pseudo-random output is never zero. Only the bench's scenarios can show the exact counter and shift-register sequences, because that needs a reference model. The same holds for the stall on invalid beats, the counter wrap, the seed reload on enable and the independent state of the two generators across mode switches. Source-only operation is shown on a second instance.

// File: rtl/tseq_pkg.sv
package tseq_pkg;

    typedef enum logic {
        SEQ_COUNT = 1'b0,
        SEQ_PRBS  = 1'b1
    } seq_mode_e;

    typedef struct packed {
        logic valid;
        logic sop;
        logic eop;
        logic sync;
    } side_t;

    localparam int unsigned LFSR_SEED = 1;

    // Galois feedback masks of maximal-length polynomials
    function automatic logic [63:0] lfsr_mask(input int unsigned w);
        case (w)
            4:       return 64'h0000_000C;
            8:       return 64'h0000_00B8;
            16:      return 64'h0000_B400;
            24:      return 64'h00E1_0000;
            32:      return 64'h8020_0003;
            default: return 64'h0;
        endcase
    endfunction

endpackage

// File: rtl/tseq_counter.sv
module tseq_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    output logic [W-1:0] cur
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)      cnt_q <= '0;
        else if (adv) cnt_q <= cnt_q + W'(1);
    end

    assign cur = cnt_q;
endmodule

// File: rtl/tseq_lfsr.sv
module tseq_lfsr
    import tseq_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         adv,
    output logic [W-1:0] cur
);
    localparam logic [W-1:0] MASK = W'(lfsr_mask(W));
    localparam logic [W-1:0] SEED = W'(LFSR_SEED);

    logic [W-1:0] st_q;
    logic         en_q;
    logic         reload;

    function automatic logic [W-1:0] step(input logic [W-1:0] s);
        return s[0] ? ((s >> 1) ^ MASK) : (s >> 1);
    endfunction

    assign reload = en & ~en_q;
    assign cur    = reload ? SEED : st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= SEED;
            en_q <= 1'b0;
        end else begin
            en_q <= en;
            if (adv)         st_q <= step(cur);
            else if (reload) st_q <= SEED;
        end
    end
endmodule

// File: rtl/tseq_source.sv
module tseq_source
    import tseq_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int CH_W      = 4,
    parameter bit HAS_INPUT = 1'b1
) (
    input  logic              en,
    input  side_t             in_side,
    input  logic [CH_W-1:0]   in_chan,
    input  logic [DATA_W-1:0] in_data,
    output side_t             src_side,
    output logic [CH_W-1:0]   src_chan,
    output logic [DATA_W-1:0] src_data
);
    generate
        if (HAS_INPUT) begin : g_stream
            assign src_side = in_side;
            assign src_chan = in_chan;
            assign src_data = in_data;
        end else begin : g_selfrun
            always_comb begin
                src_side       = '0;
                src_side.valid = en;
            end
            assign src_chan = '0;
            assign src_data = '0;
        end
    endgenerate
endmodule

// File: rtl/tseq_outreg.sv
module tseq_outreg
    import tseq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CH_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  side_t             d_side,
    input  logic [CH_W-1:0]   d_chan,
    input  logic [DATA_W-1:0] d_data,
    output side_t             q_side,
    output logic [CH_W-1:0]   q_chan,
    output logic [DATA_W-1:0] q_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_side <= '0;
            q_chan <= '0;
            q_data <= '0;
        end else begin
            q_side <= d_side;
            q_chan <= d_chan;
            q_data <= d_data;
        end
    end
endmodule

// File: rtl/tseq_inserter.sv
module tseq_inserter
    import tseq_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int SEQ_W     = 16,
    parameter int CH_W      = 4,
    parameter bit HAS_INPUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              mode,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_sync,
    input  logic [CH_W-1:0]   in_chan,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_sync,
    output logic [CH_W-1:0]   out_chan,
    output logic [DATA_W-1:0] out_data
);
    seq_mode_e         sel;
    side_t             in_side, src_side, q_side;
    logic [CH_W-1:0]   src_chan;
    logic [DATA_W-1:0] src_data, mix_data;
    logic [SEQ_W-1:0]  cnt_cur, prbs_cur, seq_cur;
    logic              beat_go;

    assign sel     = seq_mode_e'(mode);
    assign in_side = '{valid: in_valid, sop: in_sop, eop: in_eop, sync: in_sync};

    tseq_source #(.DATA_W(DATA_W), .CH_W(CH_W), .HAS_INPUT(HAS_INPUT)) u_src (
        .en       (en),
        .in_side  (in_side),
        .in_chan  (in_chan),
        .in_data  (in_data),
        .src_side (src_side),
        .src_chan (src_chan),
        .src_data (src_data)
    );

    // a valid beat is the request for the next sequence word
    assign beat_go = en & src_side.valid;

    tseq_counter #(.W(SEQ_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .adv (beat_go & (sel == SEQ_COUNT)),
        .cur (cnt_cur)
    );

    tseq_lfsr #(.W(SEQ_W)) u_prbs (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .adv (beat_go & (sel == SEQ_PRBS)),
        .cur (prbs_cur)
    );

    assign seq_cur  = (sel == SEQ_PRBS) ? prbs_cur : cnt_cur;
    assign mix_data = en ? DATA_W'(seq_cur) : src_data;

    tseq_outreg #(.DATA_W(DATA_W), .CH_W(CH_W)) u_out (
        .clk    (clk),
        .rst    (rst),
        .d_side (src_side),
        .d_chan (src_chan),
        .d_data (mix_data),
        .q_side (q_side),
        .q_chan (out_chan),
        .q_data (out_data)
    );

    assign out_valid = q_side.valid;
    assign out_sop   = q_side.sop;
    assign out_eop   = q_side.eop;
    assign out_sync  = q_side.sync;
endmodule

// File: rtl/tseq_inserter_chk.sv
module tseq_inserter_chk #(
    parameter int DATA_W    = 32,
    parameter int SEQ_W     = 16,
    parameter int CH_W      = 4,
    parameter bit HAS_INPUT = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              mode,
    input logic              in_valid,
    input logic              in_sop,
    input logic              in_eop,
    input logic              in_sync,
    input logic [CH_W-1:0]   in_chan,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic              out_sop,
    input logic              out_eop,
    input logic              out_sync,
    input logic [CH_W-1:0]   out_chan,
    input logic [DATA_W-1:0] out_data
);
    logic alive_q;
    always_ff @(posedge clk) begin
        if (rst) alive_q <= 1'b0;
        else     alive_q <= 1'b1;
    end

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !out_sop && !out_eop && !out_sync));

    // R2
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        (alive_q && HAS_INPUT && !$past(en)) |-> (out_data == $past(in_data)));

    // R11
    prbs_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (alive_q && $past(en) && $past(mode) && out_valid) |-> (out_data[SEQ_W-1:0] != '0));

    generate
        if (HAS_INPUT) begin : g_in
            // R1
            side_align_chk: assert property (@(posedge clk) disable iff (rst)
                alive_q |-> (out_valid == $past(in_valid) && out_sop == $past(in_sop) &&
                             out_eop == $past(in_eop) && out_sync == $past(in_sync) &&
                             out_chan == $past(in_chan)));
        end else begin : g_noin
            // R9
            self_valid_chk: assert property (@(posedge clk) disable iff (rst)
                alive_q |-> (out_valid == $past(en) && !out_sop && !out_eop && !out_sync));
        end
        if (SEQ_W < DATA_W) begin : g_hi
            // R8
            upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
                (alive_q && $past(en)) |-> (out_data[DATA_W-1:SEQ_W] == '0));
        end
    endgenerate
endmodule

bind tseq_inserter tseq_inserter_chk #(
    .DATA_W(DATA_W), .SEQ_W(SEQ_W), .CH_W(CH_W), .HAS_INPUT(HAS_INPUT)
) u_chk (
    .clk(clk), .rst(rst), .en(en), .mode(mode),
    .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_sync(in_sync),
    .in_chan(in_chan), .in_data(in_data),
    .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_sync(out_sync),
    .out_chan(out_chan), .out_data(out_data)
);

// File: tb/tb_tseq_inserter.sv
`timescale 1ns/1ps
module tb_tseq_inserter;
    localparam int DW = 32;
    localparam int SW = 8;
    localparam int CW = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst, en, mode, iv, isop, ieop, isync;
    logic [CW-1:0] ich;
    logic [DW-1:0] idat;
    logic          ov, osop, oeop, osync;
    logic [CW-1:0] och;
    logic [DW-1:0] odat;

    logic          en_s;
    logic          sv, ssop, seop, ssync;
    logic [CW-1:0] sch;
    logic [DW-1:0] sdat;

    tseq_inserter #(.DATA_W(DW), .SEQ_W(SW), .CH_W(CW), .HAS_INPUT(1'b1)) dut (
        .clk(clk), .rst(rst), .en(en), .mode(mode),
        .in_valid(iv), .in_sop(isop), .in_eop(ieop), .in_sync(isync),
        .in_chan(ich), .in_data(idat),
        .out_valid(ov), .out_sop(osop), .out_eop(oeop), .out_sync(osync),
        .out_chan(och), .out_data(odat)
    );

    tseq_inserter #(.DATA_W(DW), .SEQ_W(SW), .CH_W(CW), .HAS_INPUT(1'b0)) dut_src (
        .clk(clk), .rst(rst), .en(en_s), .mode(1'b0),
        .in_valid(1'b0), .in_sop(1'b0), .in_eop(1'b0), .in_sync(1'b0),
        .in_chan('0), .in_data('0),
        .out_valid(sv), .out_sop(ssop), .out_eop(seop), .out_sync(ssync),
        .out_chan(sch), .out_data(sdat)
    );

    typedef struct {
        logic          v, s, e, y;
        logic [CW-1:0] ch;
        logic [DW-1:0] d;
        string         req;
    } exp_t;

    exp_t   sb_q[$];
    int     checks = 0;
    int     fails  = 0;
    bit     done   = 1'b0;
    string  cur_req = "R1";

    // reference model state
    logic [SW-1:0] cnt_m;
    logic [SW-1:0] lf_m;
    logic          enq_m;

    // R5 Galois step with mask 0xB8 for an 8-bit sequence
    function automatic logic [SW-1:0] step8(input logic [SW-1:0] s);
        return s[0] ? ((s >> 1) ^ 8'hB8) : (s >> 1);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic drive(input logic e_i, input logic m_i, input logic v, input logic so,
                         input logic eo, input logic sy, input logic [CW-1:0] ch,
                         input logic [DW-1:0] d);
        exp_t          x;
        logic [SW-1:0] lf_cur;
        logic [SW-1:0] sq;
        @(negedge clk);
        en = e_i; mode = m_i; iv = v; isop = so; ieop = eo; isync = sy; ich = ch; idat = d;
        lf_cur = (e_i && !enq_m) ? SW'(1) : lf_m;
        sq     = m_i ? lf_cur : cnt_m;
        x.v = v; x.s = so; x.e = eo; x.y = sy; x.ch = ch;
        x.d = e_i ? DW'(sq) : d;
        x.req = cur_req;
        sb_q.push_back(x);
        if (e_i && v && !m_i) cnt_m = cnt_m + 1'b1;
        if (e_i && v && m_i)  lf_m = step8(lf_cur);
        else if (e_i)         lf_m = lf_cur;
        enq_m = e_i;
    endtask

    task automatic frame(input logic e_i, input logic m_i, input int len, input int gap);
        for (int i = 0; i < len; i++) begin
            drive(e_i, m_i, 1'b1, i == 0, i == len - 1, (i == 0) && len[0],
                  CW'(i), $urandom);
            for (int g = 0; g < gap; g++)
                drive(e_i, m_i, 1'b0, 1'b0, 1'b0, 1'b0, '0, $urandom);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t x;
                x = sb_q.pop_front();
                check({x.req, " framing"}, {ov, osop, oeop, osync, och}, {x.v, x.s, x.e, x.y, x.ch});
                check({x.req, " data"}, odat, x.d);
            end
        end
    end

    initial begin
        #500000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; en = 0; mode = 0; iv = 0; isop = 0; ieop = 0; isync = 0;
        ich = '0; idat = '0; en_s = 0;
        cnt_m = '0; lf_m = SW'(1); enq_m = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R10 outputs quiet in reset
        check("R10 reset main", {ov, osop, oeop, osync, och, odat}, '0);
        check("R10 reset source", {sv, ssop, seop, ssync, sch, sdat}, '0);
        @(negedge clk);
        rst = 1'b0;

        // R1 R2: disabled pass-through, framed with gaps
        cur_req = "R2";
        frame(1'b0, 1'b0, 4, 1);
        cur_req = "R1";
        frame(1'b0, 1'b1, 3, 0);

        // R3 R4: counter with idle gaps between beats
        cur_req = "R4";
        frame(1'b1, 1'b0, 6, 2);

        // R7: disable, then resume counter
        cur_req = "R7";
        frame(1'b0, 1'b0, 3, 0);
        frame(1'b1, 1'b0, 4, 0);

        // R3 wrap past 2^8, R8 upper bits with all-ones input data
        cur_req = "R3";
        for (int i = 0; i < 260; i++)
            drive(1'b1, 1'b0, 1'b1, i == 0, i == 259, 1'b0, '0, '1);

        // R5 R6 R11: pseudo-random over more than one period
        cur_req = "R5";
        frame(1'b1, 1'b1, 5, 1);
        cur_req = "R11";
        for (int i = 0; i < 300; i++)
            drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, '1);

        // R6: re-enable reloads seed
        cur_req = "R6";
        frame(1'b0, 1'b1, 2, 0);
        frame(1'b1, 1'b1, 4, 0);

        // R12: alternate modes, each generator keeps its own state
        cur_req = "R12";
        for (int i = 0; i < 12; i++)
            drive(1'b1, i[0], 1'b1, 1'b0, 1'b0, 1'b0, CW'(i), '0);
        frame(1'b1, 1'b0, 3, 1);
        frame(1'b1, 1'b1, 3, 1);

        cur_req = "R8";
        for (int i = 0; i < 4; i++)
            drive(1'b1, i[1], 1'b1, 1'b0, 1'b0, 1'b1, '1, '1);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
        repeat (3) @(posedge clk);

        // R9: self-running source instance
        @(negedge clk);
        en_s = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            #2;
            check("R9 source valid", {sv, ssop, seop, ssync, sch}, {1'b1, 7'd0});
            check("R9 source data", sdat, DW'(i));
        end
        @(negedge clk);
        en_s = 1'b0;
        @(posedge clk);
        #2;
        check("R9 source idle", sv, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule